// File: doc/BRIEF.md
# Parallel Configuration Data Feeder

This block streams configuration words into a target device over a parallel configuration bus. Software or a DMA engine programs a small control word (enable, active-low chip enable, reset pull, clock-to-data ratio, transfer gate and bus width), then pushes 32-bit words through a valid/ready data port. Each accepted word is placed on the bus either as one 32-bit beat or as two 16-bit beats, low half first. A data clock is generated alongside, and every beat stays on the bus for 1, 2, 4 or 8 periods of that clock.

A data clock period is two core clocks: one low, then one high. The data port drops its ready signal while a word is still going out. A word offered while the transfer gate or the enable is off is accepted and discarded, and a sticky error flag is raised. Clearing the enable forces the bus to a quiet state (clock low, data zero) and abandons any word still in progress. A mode-select input is decoded into a supported flag and a width hint, so that software can choose matching width and ratio settings.

Top module: `cfgfeed_top`

## Requirements
- R1: The control word reads back with bit 0 enable, bit 1 chip enable (active low), bit 2 reset pull, bits 7:6 ratio code, bit 8 transfer gate and bit 9 width (1 = 32 bits, 0 = 16 bits). Bits 5:3 always read as zero, and the reset value is all zero.
- R2: `cfgNce` equals control bit 1, and `cfgNconfig` is the inverse of control bit 2, so setting the pull holds the target in reset.
- R3: In 32-bit width an accepted word appears whole on `cfgData` for 2·N core cycles, where N = 1 << ratio code. `cfgDclk` starts low and alternates low, high once per core cycle, which gives N rising edges per beat.
- R4: In 16-bit width a word goes out as two beats of 2·N cycles each: bits 15:0 first, then bits 31:16, both on `cfgData[15:0]` with bits 31:16 of the bus at zero.
- R5: `dataReady` is low from the cycle after a word is accepted until its last beat ends (beats·2·N cycles). It is high in the cycle after that, and `cfgData` then returns to zero.
- R6: A word offered while enable or transfer gate is 0 is taken in (ready stays high), produces no clock and no data, and sets `xferErr`. `xferErr` stays set until reset.
- R7: While enable is 0, `cfgDclk` is low and `cfgData` is zero. Clearing enable in the middle of a word stops the bus at once and brings ready back one cycle later.
- R8: Mode-select codes 0–2, 4–6, 8–10 and 12–14 are supported, and `modeWide` is 1 exactly for the supported codes 8–14. Every other code of the 5-bit input gives `modeSupported` = 0 and `modeWide` = 0.
- R9: Width and ratio are captured when a word is accepted. A control write during the word does not change how that word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctlWe | input | 1 | Control word write strobe |
| ctlWdata | input | 10 | Control word write value |
| ctlRdata | output | 10 | Control word readback |
| modeSel | input | 5 | Mode-select input from the board |
| modeSupported | output | 1 | Mode-select code is a supported mode |
| modeWide | output | 1 | Supported mode uses 32-bit width |
| dataValid | input | 1 | Configuration word offered |
| dataWord | input | 32 | Configuration word |
| dataReady | output | 1 | Data port can take a word |
| cfgData | output | 32 | Configuration bus data |
| cfgDclk | output | 1 | Configuration data clock |
| cfgNce | output | 1 | Target chip enable, active low |
| cfgNconfig | output | 1 | Target configuration reset, active low |
| xferErr | output | 1 | Sticky flag: a word was dropped |

## Verification
The assertions assume that `dataWord` only matters in a cycle where `dataValid` and `dataReady` are both high. They also assume that control writes may land in any cycle, including mid-word, and that the drop and quiet-bus properties are judged against the control value already in place at that edge. The stimulus drives every input half a cycle away from the active edge. It only lowers `dataValid` after a handshake, and it places control writes mid-word on purpose, which exercises the capture and abort paths without breaking those assumptions.

// File: rtl/cfgfeed_pkg.sv
package cfgfeed_pkg;
  localparam int CTL_W   = 10;
  localparam int RATIO_W = 2;
  localparam int CNT_W   = (1 << RATIO_W) - 1;
  localparam logic [CTL_W-1:0] CTL_MASK = 10'h3C7;

  typedef struct packed {
    logic              wide;
    logic              xferEn;
    logic [RATIO_W-1:0] ratio;
    logic [2:0]        unused;
    logic              pull;
    logic              nce;
    logic              en;
  } ctlFields_t;

  typedef struct packed {
    logic load;
    logic wide;
    logic drive;
    logic dclk;
    logic upper;
  } feedStrobe_t;
endpackage

// File: rtl/cfgfeed_ctrl.sv
module cfgfeed_ctrl
  import cfgfeed_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWe,
  input  logic [CTL_W-1:0] ctlWdata,
  output ctlFields_t       ctl,
  input  logic             dataValid,
  output logic             dataReady,
  output logic             xferErr,
  output feedStrobe_t      strobe
);
  logic busy, phase, beatHi, wideLat;
  logic [RATIO_W-1:0] ratioLat;
  logic [CNT_W-1:0] periodCnt;
  logic take, start, periodLast, beatLast;

  assign take       = dataValid && dataReady;
  assign start      = take && ctl.en && ctl.xferEn;
  assign periodLast = periodCnt == ((CNT_W'(1) << ratioLat) - CNT_W'(1));
  assign beatLast   = wideLat || beatHi;
  assign dataReady  = !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl <= '0;
    end else if (ctlWe) begin
      ctl <= ctlFields_t'(ctlWdata & CTL_MASK);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferErr <= 1'b0;
    end else if (take && !(ctl.en && ctl.xferEn)) begin
      xferErr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      phase     <= 1'b0;
      beatHi    <= 1'b0;
      wideLat   <= 1'b0;
      ratioLat  <= '0;
      periodCnt <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      phase     <= 1'b0;
      beatHi    <= 1'b0;
      wideLat   <= ctl.wide;
      ratioLat  <= ctl.ratio;
      periodCnt <= '0;
    end else if (busy && !ctl.en) begin
      busy  <= 1'b0;
      phase <= 1'b0;
    end else if (busy) begin
      if (!phase) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        if (periodLast) begin
          periodCnt <= '0;
          if (beatLast) busy <= 1'b0;
          else          beatHi <= 1'b1;
        end else begin
          periodCnt <= periodCnt + CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    strobe.load  = start;
    strobe.wide  = ctl.wide;
    strobe.drive = busy && ctl.en;
    strobe.dclk  = phase;
    strobe.upper = beatHi;
  end
endmodule

// File: rtl/cfgfeed_dp.sv
module cfgfeed_dp
  import cfgfeed_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  feedStrobe_t       strobe,
  input  logic [DATA_W-1:0] dataWord,
  input  logic [4:0]        modeSel,
  output logic              modeSupported,
  output logic              modeWide,
  output logic [DATA_W-1:0] cfgData,
  output logic              cfgDclk
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] wordReg;
  logic wideReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
      wideReg <= 1'b0;
    end else if (strobe.load) begin
      wordReg <= dataWord;
      wideReg <= strobe.wide;
    end
  end

  always_comb begin
    if (!strobe.drive)  cfgData = '0;
    else if (wideReg)   cfgData = wordReg;
    else if (strobe.upper) cfgData = {{HALF{1'b0}}, wordReg[DATA_W-1:HALF]};
    else                cfgData = {{HALF{1'b0}}, wordReg[HALF-1:0]};
  end

  assign cfgDclk       = strobe.drive && strobe.dclk;
  assign modeSupported = !modeSel[4] && (modeSel[1:0] != 2'b11);
  assign modeWide      = modeSupported && modeSel[3];
endmodule

// File: rtl/cfgfeed_top.sv
module cfgfeed_top
  import cfgfeed_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWe,
  input  logic [CTL_W-1:0]  ctlWdata,
  output logic [CTL_W-1:0]  ctlRdata,
  input  logic [4:0]        modeSel,
  output logic              modeSupported,
  output logic              modeWide,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataWord,
  output logic              dataReady,
  output logic [DATA_W-1:0] cfgData,
  output logic              cfgDclk,
  output logic              cfgNce,
  output logic              cfgNconfig,
  output logic              xferErr
);
  ctlFields_t  ctl;
  feedStrobe_t strobe;

  cfgfeed_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ctlWe(ctlWe), .ctlWdata(ctlWdata), .ctl(ctl),
    .dataValid(dataValid), .dataReady(dataReady), .xferErr(xferErr), .strobe(strobe)
  );

  cfgfeed_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataWord(dataWord),
    .modeSel(modeSel), .modeSupported(modeSupported), .modeWide(modeWide),
    .cfgData(cfgData), .cfgDclk(cfgDclk)
  );

  assign ctlRdata   = ctl;
  assign cfgNce     = ctl.nce;
  assign cfgNconfig = !ctl.pull;
endmodule

// File: rtl/cfgfeed_chk.sv
module cfgfeed_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [9:0]        ctlRdata,
  input logic              dataValid,
  input logic              dataReady,
  input logic [DATA_W-1:0] cfgData,
  input logic              cfgDclk,
  input logic              xferErr
);
  assert_dclk_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgDclk |=> !cfgDclk);

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgDclk |-> $stable(cfgData));

  assert_ready_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    cfgDclk |-> !dataReady);

  assert_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && dataReady && !(ctlRdata[0] && ctlRdata[8])) |=> (!cfgDclk && xferErr));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    xferErr |=> xferErr);

  assert_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctlRdata[0] |-> (!cfgDclk && cfgData == '0));
endmodule

bind cfgfeed_top cfgfeed_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .ctlRdata(ctlRdata), .dataValid(dataValid),
  .dataReady(dataReady), .cfgData(cfgData), .cfgDclk(cfgDclk), .xferErr(xferErr)
);

// File: tb/sim_cfgfeed_top.sv
`timescale 1ns/1ps
module sim_cfgfeed_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlWe = 1'b0;
  logic [9:0] ctlWdata = '0;
  logic [9:0] ctlRdata;
  logic [4:0] modeSel = '0;
  logic modeSupported, modeWide;
  logic dataValid = 1'b0;
  logic [31:0] dataWord = '0;
  logic dataReady;
  logic [31:0] cfgData;
  logic cfgDclk, cfgNce, cfgNconfig, xferErr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfgfeed_top u0 (
    .clk(clk), .rstN(rstN), .ctlWe(ctlWe), .ctlWdata(ctlWdata), .ctlRdata(ctlRdata),
    .modeSel(modeSel), .modeSupported(modeSupported), .modeWide(modeWide),
    .dataValid(dataValid), .dataWord(dataWord), .dataReady(dataReady),
    .cfgData(cfgData), .cfgDclk(cfgDclk), .cfgNce(cfgNce), .cfgNconfig(cfgNconfig),
    .xferErr(xferErr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeCtl(input logic [9:0] v);
    @(negedge clk);
    ctlWe = 1'b1; ctlWdata = v;
    @(negedge clk);
    ctlWe = 1'b0;
  endtask

  function automatic logic [9:0] mkCtl(input bit en, input bit xfer, input bit wide, input int ratio);
    return {wide, xfer, 2'(ratio), 3'b000, 1'b0, 1'b0, en};
  endfunction

  // Offer one word and follow it cycle by cycle; chgAt >= 0 writes chgVal there.
  task automatic sendWord(input logic [31:0] w, input bit wide, input int ratio,
                          input int chgAt, input logic [9:0] chgVal, input string req);
    int n, beats, total;
    logic [31:0] expData;
    n = 1 << ratio;
    beats = wide ? 1 : 2;
    total = beats * 2 * n;
    @(negedge clk);
    chk(dataReady === 1'b1, "R5 ready before word", {31'b0, dataReady}, 32'd1);
    dataValid = 1'b1; dataWord = w;
    @(negedge clk);
    dataValid = 1'b0;
    for (int i = 0; i < total; i++) begin
      if (wide) expData = w;
      else if (i / (2 * n) == 0) expData = {16'h0, w[15:0]};
      else expData = {16'h0, w[31:16]};
      chk(cfgData === expData, req, cfgData, expData);
      chk(cfgDclk === 1'(i % 2), {req, " dclk"}, {31'b0, cfgDclk}, 32'(i % 2));
      chk(dataReady === 1'b0, "R5 ready low while sending", {31'b0, dataReady}, 32'd0);
      if (i == chgAt) begin ctlWe = 1'b1; ctlWdata = chgVal; end
      else ctlWe = 1'b0;
      @(negedge clk);
    end
    ctlWe = 1'b0;
    chk(dataReady === 1'b1, "R5 ready after word", {31'b0, dataReady}, 32'd1);
    chk(cfgData === 32'h0, "R5 bus idle after word", cfgData, 32'h0);
    chk(cfgDclk === 1'b0, "R5 dclk idle after word", {31'b0, cfgDclk}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctlRdata === 10'h0, "R1 reset control", {22'b0, ctlRdata}, 32'h0);
    chk(dataReady === 1'b1 && cfgDclk === 1'b0 && cfgData === 0, "R7 reset bus idle", cfgData, 32'h0);
    chk(xferErr === 1'b0, "R6 reset error flag", {31'b0, xferErr}, 32'd0);

    // R1 readback with reserved bits 5:3 masked
    writeCtl(10'h3FF);
    chk(ctlRdata === 10'h3C7, "R1 readback mask", {22'b0, ctlRdata}, 32'h3C7);
    // R2 pin mapping
    chk(cfgNce === 1'b1 && cfgNconfig === 1'b0, "R2 pins with pull set", {30'b0, cfgNce, cfgNconfig}, 32'h2);
    writeCtl(10'h001);
    chk(cfgNce === 1'b0 && cfgNconfig === 1'b1, "R2 pins with pull clear", {30'b0, cfgNce, cfgNconfig}, 32'h1);
    chk(ctlRdata === 10'h001, "R1 readback enable only", {22'b0, ctlRdata}, 32'h1);

    // R8 mode decode sweep
    for (int m = 0; m < 32; m++) begin
      bit sup, wd;
      modeSel = 5'(m);
      sup = (m < 16) && (m % 4 != 3);
      wd = sup && (m >= 8);
      #1;
      chk(modeSupported === sup, "R8 mode supported", {31'b0, modeSupported}, {31'b0, sup});
      chk(modeWide === wd, "R8 mode wide", {31'b0, modeWide}, {31'b0, wd});
    end

    // R3 / R4 sweep over width and ratio
    for (int wd = 0; wd < 2; wd++) begin
      for (int r = 0; r < 4; r++) begin
        writeCtl(mkCtl(1, 1, wd[0], r));
        for (int k = 0; k < 2; k++) begin
          w = 32'hA5C3_1E7F ^ (32'h1357_9BDF * (wd * 8 + r * 2 + k + 1));
          sendWord(w, wd[0], r, -1, 10'h0, wd ? "R3 wide beat" : "R4 half beat");
        end
      end
    end
    chk(xferErr === 1'b0, "R6 no error after valid words", {31'b0, xferErr}, 32'd0);

    // R9 mid-word control change does not alter the word in flight
    writeCtl(mkCtl(1, 1, 1, 1));
    sendWord(32'hDEAD_BEEF, 1'b1, 1, 1, mkCtl(1, 1, 0, 3), "R9 captured width and ratio");
    sendWord(32'h0BAD_F00D, 1'b0, 3, -1, 10'h0, "R9 new settings on next word");

    // R6 drop with enable off
    writeCtl(mkCtl(0, 1, 1, 0));
    @(negedge clk);
    chk(dataReady === 1'b1, "R6 ready with enable off", {31'b0, dataReady}, 32'd1);
    dataValid = 1'b1; dataWord = 32'h1234_5678;
    @(negedge clk);
    dataValid = 1'b0;
    chk(cfgDclk === 1'b0 && cfgData === 0, "R6 dropped word silent", cfgData, 32'h0);
    chk(xferErr === 1'b1, "R6 error raised", {31'b0, xferErr}, 32'd1);
    chk(dataReady === 1'b1, "R6 ready after drop", {31'b0, dataReady}, 32'd1);
    // R6 drop with transfer gate off
    writeCtl(mkCtl(1, 0, 1, 0));
    dataValid = 1'b1; dataWord = 32'h8765_4321;
    @(negedge clk);
    dataValid = 1'b0;
    repeat (2) begin
      chk(cfgDclk === 1'b0 && cfgData === 0 && dataReady === 1'b1, "R6 gate off drop", cfgData, 32'h0);
      @(negedge clk);
    end

    // R7 abort mid-word by clearing enable
    writeCtl(mkCtl(1, 1, 1, 3));
    dataValid = 1'b1; dataWord = 32'hCAFE_0001;
    @(negedge clk);
    dataValid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(cfgData === 32'hCAFE_0001, "R7 before abort", cfgData, 32'hCAFE_0001);
      if (i == 3) begin ctlWe = 1'b1; ctlWdata = mkCtl(0, 1, 1, 3); end
      @(negedge clk);
    end
    ctlWe = 1'b0;
    chk(cfgData === 0 && cfgDclk === 1'b0, "R7 bus quiet at once", cfgData, 32'h0);
    chk(dataReady === 1'b0, "R7 ready one cycle later", {31'b0, dataReady}, 32'd0);
    @(negedge clk);
    chk(dataReady === 1'b1, "R7 ready back", {31'b0, dataReady}, 32'd1);
    chk(cfgData === 0 && cfgDclk === 1'b0, "R7 bus quiet after abort", cfgData, 32'h0);
    chk(xferErr === 1'b1, "R6 error still sticky", {31'b0, xferErr}, 32'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule